// File: doc/BRIEF.md
# Table-Driven Entropy Decoder for Baseline Image Blocks

The block turns a byte stream of entropy-coded image data into quantized frequency coefficients, one 8x8 block at a time. It does not build a code tree. Software first writes four canonical code tables, each as sixteen per-length code counts followed by the symbols in code order. The decoder then rebuilds the codes on the fly from a running first-code and symbol offset per length, and walks the stream one bit per cycle. Each bit picks the 0 or 1 branch until a code of the current table matches.

The four tables are indexed by two bits: component class (luma or chroma) and coefficient kind (DC or AC). The two chroma components share the chroma pair. A DC symbol gives the bit size of a difference against the previous DC value of the same component. An AC symbol packs a zero run and a value size, with one code for end-of-block and one for sixteen zeros. The block emits all 64 coefficients of a block in zig-zag sequence order, zeros included, and flags the last one. Byte stuffing after 0xFF is removed at the input.

A block is started with a pulse carrying its component number while the decoder is idle. Blocks are bit-contiguous in the stream. A scan-reset pulse clears the DC predictors and drops any partially used byte.

Top module: `jpeg_huff_dec`

## Requirements
- R1: Four table slots are addressed by `tab_sel`, where bit 1 is set for chroma and bit 0 is set for AC. Component 0 (luma) decodes with slots 0 and 1. Components 1 and 2 (the two chroma components) both decode with slots 2 and 3.
- R2: A count write (`tab_kind`=0) stores at `tab_addr[3:0]` = code length minus one. A symbol write (`tab_kind`=1) stores at `tab_addr` = position in code order. Codes are read MSB first. The first code of length 1 is 0, and the first code of length L+1 is twice the sum of the first code of length L and the count of length L.
- R3: Every started block yields exactly 64 `coef_valid` outputs with `coef_idx` 0, 1, ... 63 in order. `blk_done` is raised with index 63, and `busy` is low by then. A block whose AC data reaches index 63 ends without an end-of-block code.
- R4: The index-0 output is the component's predictor plus the decoded difference, and it becomes the new predictor. Components 0, 1 and 2 keep separate predictors. `scan_rst` sets all predictors to 0 and discards buffered bits.
- R5: An AC symbol's high nibble is a zero run and its low nibble is a value size. The run's zeros are output before the value.
- R6: The AC symbol 0x00 outputs zeros for all remaining indices of the block.
- R7: The AC symbol 0xF0 outputs sixteen zeros and decoding continues in the same block.
- R8: A value of size s is the next s stream bits. If the leading bit is 1, the value is the raw bits. If it is 0, the value is raw minus (2^s - 1). A DC size of 0 means a difference of 0.
- R9: An input byte 0x00 that directly follows an accepted 0xFF is dropped, and the 0xFF is used as data.
- R10: During and right after reset, `busy`, `coef_valid` and `blk_done` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_rst | input | 1 | Start of scan: clears predictors and bit buffer |
| tab_we | input | 1 | Table write strobe |
| tab_kind | input | 1 | 0 = count write, 1 = symbol write |
| tab_sel | input | 2 | Table slot (bit 1 chroma, bit 0 AC) |
| tab_addr | input | SYM_AW | Length-1 for counts, symbol position for symbols |
| tab_data | input | 8 | Count or symbol value |
| in_valid | input | 1 | Stream byte present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| blk_go | input | 1 | Start one block (used when idle) |
| blk_chan | input | 2 | Component of the block: 0 luma, 1 and 2 chroma |
| busy | output | 1 | A block is being decoded |
| coef_valid | output | 1 | Coefficient output valid |
| coef_idx | output | 6 | Zig-zag sequence index of the coefficient |
| coef_val | output | OUT_W | Signed coefficient value |
| blk_done | output | 1 | Last coefficient of the block |

## Verification
The assertions take for granted that every code in the stream exists in the selected table. They also assume each table holds a consistent canonical set, `blk_go` arrives only while `busy` is low, and tables are not rewritten while a block is in flight. The stimulus keeps to this by loading all four tables before any stream byte. It encodes only codes from those tables and waits for `busy` to fall before each start pulse. The scan reset is pulsed only once all outputs of the earlier blocks have been seen and the byte feeder is idle.

// File: rtl/jpeg_huff_dec.sv
module jpeg_huff_dec #(
  parameter int SYM_AW = 8,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_rst,
  input  logic              tab_we,
  input  logic              tab_kind,
  input  logic [1:0]        tab_sel,
  input  logic [SYM_AW-1:0] tab_addr,
  input  logic [7:0]        tab_data,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  input  logic              blk_go,
  input  logic [1:0]        blk_chan,
  output logic              busy,
  output logic              coef_valid,
  output logic [5:0]        coef_idx,
  output logic [OUT_W-1:0]  coef_val,
  output logic              blk_done
);
  localparam int NSYM = 1 << SYM_AW;
  localparam int NLEN = 16;
  localparam int CW   = 18;

  typedef enum logic [2:0] {S_IDLE, S_HUFF, S_MAG, S_ZRUN, S_FILL} st_t;

  logic [7:0] cnt_q [4][NLEN];
  logic [7:0] sym_q [4][NSYM];

  st_t             st;
  logic [1:0]      chan, tsel;
  logic [5:0]      pos;
  logic [14:0]     code;
  logic [3:0]      clen, size, mcnt;
  logic [9:0]      mag;
  logic [4:0]      run;
  logic            go_mag;
  logic [OUT_W-1:0] pred [4];

  logic [7:0] cur;
  logic [3:0] nbits;
  logic       ff_seen;

  assign in_ready = (nbits == 4'd0);
  assign busy     = (st != S_IDLE);

  wire bit_in = cur[7];
  wire take   = (nbits != 4'd0) && (st == S_HUFF || st == S_MAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0; nbits <= '0; ff_seen <= 1'b0;
    end else if (scan_rst) begin
      nbits <= '0; ff_seen <= 1'b0;
    end else if (in_valid && in_ready) begin
      if (ff_seen && in_byte == 8'h00) ff_seen <= 1'b0;
      else begin
        cur <= in_byte; nbits <= 4'd8; ff_seen <= (in_byte == 8'hFF);
      end
    end else if (take) begin
      cur <= {cur[6:0], 1'b0}; nbits <= nbits - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 4; t++)
        for (int k = 0; k < NLEN; k++) cnt_q[t][k] <= '0;
    end else if (tab_we && !tab_kind) begin
      cnt_q[tab_sel][tab_addr[3:0]] <= tab_data;
    end
  end

  always_ff @(posedge clk) begin
    if (tab_we && tab_kind) sym_q[tab_sel][tab_addr] <= tab_data;
  end

  logic [CW-1:0] f_acc, o_acc, fc, oc;
  always_comb begin
    f_acc = '0; o_acc = '0; fc = '0; oc = '0;
    for (int k = 0; k < NLEN; k++) begin
      if (k == int'(clen)) begin fc = f_acc; oc = o_acc; end
      f_acc = (f_acc + CW'(cnt_q[tsel][k])) << 1;
      o_acc = o_acc + CW'(cnt_q[tsel][k]);
    end
  end

  wire [15:0]   nc  = {code, bit_in};
  wire [CW-1:0] dlt = CW'(nc) - fc;
  wire          hit = (CW'(nc) >= fc) && (dlt < CW'(cnt_q[tsel][clen]));
  wire [7:0]    sym = sym_q[tsel][SYM_AW'(oc + dlt)];

  function automatic logic [OUT_W-1:0] mag_val(input logic [10:0] raw, input logic [3:0] s);
    int r;
    r = int'(raw);
    if (s == 4'd0) return '0;
    if (((r >> (int'(s) - 1)) & 1) == 1) return OUT_W'(r);
    return OUT_W'(r - ((1 << s) - 1));
  endfunction

  wire [10:0]      m_next = {mag, bit_in};
  wire             mdone  = (mcnt + 4'd1) == size;
  wire [OUT_W-1:0] mval   = mag_val(m_next, size);

  logic            emit;
  logic [OUT_W-1:0] ev;
  always_comb begin
    emit = 1'b0; ev = '0;
    case (st)
      S_HUFF: if (take && hit && !tsel[0] && sym[3:0] == 4'd0) begin emit = 1'b1; ev = pred[chan]; end
      S_MAG:  if (take && mdone) begin emit = 1'b1; ev = tsel[0] ? mval : pred[chan] + mval; end
      S_ZRUN, S_FILL: emit = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; chan <= '0; tsel <= '0; pos <= '0; code <= '0; clen <= '0;
      size <= '0; mcnt <= '0; mag <= '0; run <= '0; go_mag <= 1'b0;
      for (int c = 0; c < 4; c++) pred[c] <= '0;
      coef_valid <= 1'b0; coef_idx <= '0; coef_val <= '0; blk_done <= 1'b0;
    end else begin
      coef_valid <= emit;
      blk_done   <= emit && pos == 6'd63;
      if (emit) begin coef_idx <= pos; coef_val <= ev; end
      case (st)
        S_IDLE: if (blk_go) begin
          st <= S_HUFF; chan <= blk_chan; tsel <= {blk_chan != 2'd0, 1'b0};
          pos <= '0; code <= '0; clen <= '0;
        end
        S_HUFF: if (take) begin
          if (hit) begin
            code <= '0; clen <= '0; size <= sym[3:0]; mag <= '0; mcnt <= '0;
            if (!tsel[0]) begin
              if (sym[3:0] == 4'd0) begin
                tsel[0] <= 1'b1; pos <= pos + 6'd1;
              end else st <= S_MAG;
            end else if (sym[3:0] == 4'd0) begin
              if (sym[7:4] == 4'hF) begin run <= 5'd16; go_mag <= 1'b0; st <= S_ZRUN; end
              else st <= S_FILL;
            end else if (sym[7:4] == 4'd0) st <= S_MAG;
            else begin run <= {1'b0, sym[7:4]}; go_mag <= 1'b1; st <= S_ZRUN; end
          end else if (clen == 4'd15) st <= S_FILL;
          else begin code <= nc[14:0]; clen <= clen + 4'd1; end
        end
        S_MAG: if (take) begin
          mag <= m_next[9:0]; mcnt <= mcnt + 4'd1;
          if (mdone) begin
            if (!tsel[0]) pred[chan] <= ev;
            tsel[0] <= 1'b1;
            pos <= pos + 6'd1;
            st <= (pos == 6'd63) ? S_IDLE : S_HUFF;
          end
        end
        S_ZRUN: begin
          pos <= pos + 6'd1; run <= run - 5'd1;
          if (pos == 6'd63) st <= S_IDLE;
          else if (run == 5'd1) st <= go_mag ? S_MAG : S_HUFF;
        end
        S_FILL: begin
          pos <= pos + 6'd1;
          if (pos == 6'd63) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (scan_rst) for (int c = 0; c < 4; c++) pred[c] <= '0;
    end
  end
endmodule

// File: rtl/jpeg_huff_dec_chk.sv
module jpeg_huff_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       coef_valid,
  input logic [5:0] coef_idx,
  input logic       blk_done
);
  logic [5:0] exp_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_idx <= '0;
    else if (coef_valid) exp_idx <= blk_done ? 6'd0 : coef_idx + 6'd1;
  end

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid |-> coef_idx == exp_idx);
  p_done_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> coef_valid && coef_idx == 6'd63);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> !busy);
  p_out_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coef_valid |-> $past(busy));
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !coef_valid && !blk_done);
endmodule

bind jpeg_huff_dec jpeg_huff_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .coef_valid(coef_valid),
  .coef_idx(coef_idx), .blk_done(blk_done)
);

// File: tb/jpeg_huff_dec_tb.sv
`timescale 1ns/1ps
module jpeg_huff_dec_tb;
  localparam int OUT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, scan_rst = 1'b0;
  logic tab_we = 1'b0, tab_kind = 1'b0;
  logic [1:0] tab_sel = '0;
  logic [7:0] tab_addr = '0, tab_data = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, busy, coef_valid, blk_done;
  logic blk_go = 1'b0;
  logic [1:0] blk_chan = '0;
  logic [5:0] coef_idx;
  logic [OUT_W-1:0] coef_val;

  jpeg_huff_dec u_dut (
    .clk(clk), .rst_n(rst_n), .scan_rst(scan_rst), .tab_we(tab_we), .tab_kind(tab_kind),
    .tab_sel(tab_sel), .tab_addr(tab_addr), .tab_data(tab_data), .in_valid(in_valid),
    .in_byte(in_byte), .in_ready(in_ready), .blk_go(blk_go), .blk_chan(blk_chan),
    .busy(busy), .coef_valid(coef_valid), .coef_idx(coef_idx), .coef_val(coef_val),
    .blk_done(blk_done)
  );

  always #2 clk = ~clk;

  // row: [32] dc, [31:28] code, [27:25] code length, [24:17] symbol, [16:6] magnitude bits, [5:4] component, [3:0] tag
  localparam logic [32:0] ROWS [38] = '{
    {1'b1,4'b0001,3'd2,8'h02,11'd2,2'd0,4'd8},   // R8 luma DC +2
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd5},   // R5
    {1'b0,4'b1100,3'd4,8'h02,11'd1,2'd0,4'd8},   // R8 -2 (R2 length 4)
    {1'b0,4'b1101,3'd4,8'h31,11'd0,2'd0,4'd5},   // R5 run 3
    {1'b0,4'b0000,3'd2,8'h00,11'd0,2'd0,4'd6},   // R6
    {1'b1,4'b0000,3'd1,8'h01,11'd0,2'd1,4'd1},   // R1 chroma DC table
    {1'b0,4'b0110,3'd3,8'hF0,11'd0,2'd1,4'd7},   // R7
    {1'b0,4'b0111,3'd3,8'h21,11'd1,2'd1,4'd1},
    {1'b0,4'b0010,3'd2,8'h02,11'd3,2'd1,4'd1},
    {1'b0,4'b0000,3'd1,8'h00,11'd0,2'd1,4'd6},
    {1'b1,4'b0110,3'd3,8'h05,11'd0,2'd2,4'd4},   // R4 Cr separate predictor
    {1'b0,4'b0000,3'd1,8'h00,11'd0,2'd2,4'd6},
    {1'b1,4'b0110,3'd3,8'h0B,11'h7FF,2'd0,4'd9}, // R9 stream holds 0xFF
    {1'b0,4'b0000,3'd2,8'h00,11'd0,2'd0,4'd6},
    {1'b1,4'b0010,3'd2,8'h00,11'd0,2'd1,4'd4},   // R4 size 0 keeps predictor
    {1'b0,4'b0110,3'd3,8'hF0,11'd0,2'd1,4'd7},
    {1'b0,4'b0110,3'd3,8'hF0,11'd0,2'd1,4'd7},
    {1'b0,4'b0110,3'd3,8'hF0,11'd0,2'd1,4'd7},
    {1'b0,4'b0111,3'd3,8'h21,11'd0,2'd1,4'd8},
    {1'b0,4'b0000,3'd1,8'h00,11'd0,2'd1,4'd6},
    {1'b1,4'b0000,3'd2,8'h00,11'd0,2'd0,4'd4},
    {1'b0,4'b0101,3'd3,8'hF0,11'd0,2'd0,4'd7},
    {1'b0,4'b0101,3'd3,8'hF0,11'd0,2'd0,4'd7},
    {1'b0,4'b0101,3'd3,8'hF0,11'd0,2'd0,4'd7},
    {1'b0,4'b1101,3'd4,8'h31,11'd1,2'd0,4'd5},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},   // R3 ends at 63 with no end code
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b0,4'b0001,3'd2,8'h01,11'd1,2'd0,4'd3},
    {1'b1,4'b0001,3'd2,8'h02,11'd1,2'd0,4'd4},   // R4 after scan reset: 0 + (-2)
    {1'b0,4'b0000,3'd2,8'h00,11'd0,2'd0,4'd6}
  };

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  int exp_idx [1024];
  int exp_val [1024];
  int exp_tag [1024];
  int nexp = 0, ngot = 0, ndone = 0;
  bit bitq [4096];
  int nb;
  logic [7:0] byt [1024];
  int nby;
  int blkch [16];
  int nblk = 0;
  int pred [3] = '{0, 0, 0};
  int pos;

  task automatic check(input bit ok, input string tag, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int bmag(input int s, input int b);
    if (s == 0) return 0;
    if (((b >> (s - 1)) & 1) == 1) return b;
    return b - ((1 << s) - 1);
  endfunction

  task automatic push(input int v, input int tag);
    exp_idx[nexp] = pos; exp_val[nexp] = v; exp_tag[nexp] = tag;
    nexp++; pos++;
  endtask

  task automatic put(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) begin bitq[nb] = v[i]; nb++; end
  endtask

  task automatic build(input int a, input int b);
    nb = 0;
    for (int i = a; i <= b; i++) begin
      logic [32:0] r;
      int code, len, sym, bits, ch, tag, s, rn;
      r = ROWS[i];
      code = int'(r[31:28]); len = int'(r[27:25]); sym = int'(r[24:17]);
      bits = int'(r[16:6]); ch = int'(r[5:4]); tag = int'(r[3:0]);
      s = sym & 15; rn = sym >> 4;
      put(code, len);
      put(bits, s);
      if (r[32]) begin
        blkch[nblk] = ch; nblk++;
        pos = 0;
        pred[ch] = pred[ch] + bmag(s, bits);
        push(pred[ch], tag);
      end else if (s == 0 && rn == 15) begin
        for (int z = 0; z < 16; z++) push(0, tag);
      end else if (s == 0) begin
        while (pos < 64) push(0, 6);
      end else begin
        for (int z = 0; z < rn; z++) push(0, tag);
        push(bmag(s, bits), tag);
      end
    end
    while (nb % 8 != 0) begin bitq[nb] = 1'b1; nb++; end
    nby = 0;
    for (int k = 0; k < nb / 8; k++) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[7-j] = bitq[k*8+j];
      byt[nby] = v; nby++;
      if (v == 8'hFF && k != nb / 8 - 1) begin byt[nby] = 8'h00; nby++; end
    end
  endtask

  task automatic feed();
    for (int i = 0; i < nby; i++) begin
      in_byte = byt[i]; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic starter(input int b0, input int b1);
    for (int i = b0; i < b1; i++) begin
      while (busy) @(negedge clk);
      blk_chan = 2'(blkch[i]); blk_go = 1'b1;
      @(negedge clk);
      blk_go = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic ld(input int kind, input int sel, input int addr, input int data);
    tab_we = 1'b1; tab_kind = kind[0]; tab_sel = 2'(sel); tab_addr = 8'(addr); tab_data = 8'(data);
    @(negedge clk);
    tab_we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && coef_valid) begin
      if (ngot >= nexp) check(1'b0, "R3", int'(coef_idx), -1, "extra coefficient");
      else begin
        string t;
        t = $sformatf("R%0d", exp_tag[ngot]);
        check(int'(coef_idx) == exp_idx[ngot], t, int'(coef_idx), exp_idx[ngot], "index");
        check(int'($signed(coef_val)) == exp_val[ngot], t, int'($signed(coef_val)), exp_val[ngot],
              $sformatf("value at index %0d", exp_idx[ngot]));
        check(blk_done == (exp_idx[ngot] == 63), "R3", int'(blk_done), int'(exp_idx[ngot] == 63), "done flag");
        ngot++;
      end
      if (blk_done) ndone++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !coef_valid && !blk_done, "R10", int'({busy, coef_valid, blk_done}), 0, "outputs in reset");
    check(in_ready, "R10", int'(in_ready), 1, "in_ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !coef_valid && !blk_done, "R10", int'({busy, coef_valid, blk_done}), 0, "outputs after reset");
    check(in_ready, "R10", int'(in_ready), 1, "in_ready after reset");

    // R2 tables: counts by length-1, symbols in code order; R1 slot bit1 chroma, bit0 AC
    ld(0, 0, 1, 3); ld(0, 0, 2, 1);
    ld(1, 0, 0, 8'h00); ld(1, 0, 1, 8'h02); ld(1, 0, 2, 8'h03); ld(1, 0, 3, 8'h0B);
    ld(0, 1, 1, 2); ld(0, 1, 2, 2); ld(0, 1, 3, 2);
    ld(1, 1, 0, 8'h00); ld(1, 1, 1, 8'h01); ld(1, 1, 2, 8'h11); ld(1, 1, 3, 8'hF0);
    ld(1, 1, 4, 8'h02); ld(1, 1, 5, 8'h31);
    ld(0, 2, 0, 1); ld(0, 2, 1, 1); ld(0, 2, 2, 1);
    ld(1, 2, 0, 8'h01); ld(1, 2, 1, 8'h00); ld(1, 2, 2, 8'h05);
    ld(0, 3, 0, 1); ld(0, 3, 1, 1); ld(0, 3, 2, 2);
    ld(1, 3, 0, 8'h00); ld(1, 3, 1, 8'h02); ld(1, 3, 2, 8'hF0); ld(1, 3, 3, 8'h21);

    b0 = nblk;
    build(0, 35);
    fork
      feed();
      starter(b0, nblk);
    join
    while (ngot < nexp) @(negedge clk);

    // R4 scan reset zeroes predictors and drops leftover bits
    scan_rst = 1'b1; @(negedge clk); scan_rst = 1'b0; @(negedge clk);
    pred = '{0, 0, 0};
    b0 = nblk;
    build(36, 37);
    fork
      feed();
      starter(b0, nblk);
    join
    while (ngot < nexp) @(negedge clk);
    @(negedge clk);

    check(ndone == 7, "R3", ndone, 7, "blocks completed");
    check(!busy, "R3", int'(busy), 0, "idle after last block");
    check(ngot == nexp, "R3", ngot, nexp, "coefficient count");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule